// File: doc/BRIEF.md
# Freezable Instruction Cache

This block sits between a processor's instruction fetch port and an external program memory. It holds a few lines of instruction words in a fully associative array. A fetch that finds its line present is answered from the array. A fetch that does not goes out to memory. When updates are allowed, the missing line is loaded one word at a time, and the line chosen for replacement is the one least recently used.

Three control bits steer it: an enable bit, a freeze bit and a self-clearing clear bit. While frozen, the cache still answers hits. It never allocates a line, never overwrites one and never reorders its usage history. The clear bit empties the cache whether or not it is frozen. If a clear arrives in the middle of a line load, the load is abandoned as soon as the requesting fetch has its word.

Top module: `ifetch_cache`

## Requirements
- R1: After reset, the enable and freeze bits are 0 and `ctl_status` reads 0. No line is valid, `fetch_valid` and `mem_req` are low, and `fetch_ready` is high.
- R2: While enable is 0, every fetch reads exactly one word from memory and answers with `fetch_hit`=0. It allocates nothing, so the same address still misses once the cache is enabled.
- R3: With enable=1 and freeze=0, a miss loads the whole 4-word line into the cache. The words are read in ascending address order, from line offset 0 up to offset 3, and the requested word is returned when its beat arrives. Afterwards, any word of that line hits.
- R4: A hit is answered in the cycle after the request is accepted, with `fetch_valid`=1 and `fetch_hit`=1.
- R5: Every hit, and every completed load while not frozen, makes the line used the most recently used. A load always replaces the least recently used line. After reset, lines are replaced in the order 3, 2, 1, 0.
- R6: While frozen, hits are still served. A miss reads only the requested word from memory and allocates nothing, so repeating the same address misses again.
- R7: While frozen, hits do not change the replacement order.
- R8: A control write with the clear bit set makes every line invalid. This works both when the cache is frozen and when it is not.
- R9: A clear that arrives during a line load abandons the load. The requested word is still returned, no memory beat is issued after it, and the line being loaded stays invalid.
- R10: `ctl_status` bit 0 is the enable bit and bit 1 is the freeze bit, both as last written. Bit 2 is the clear bit and always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_en | input | 1 | Enable value to write |
| ctl_frz | input | 1 | Freeze value to write |
| ctl_clr | input | 1 | Clear request (self-clearing) |
| ctl_status | output | 3 | Control readback {clear=0, freeze, enable} |
| fetch_req | input | 1 | Fetch request, accepted when `fetch_ready` is high |
| fetch_addr | input | AW | Fetch word address |
| fetch_ready | output | 1 | Cache is idle and can accept a fetch |
| fetch_valid | output | 1 | One-cycle response strobe |
| fetch_hit | output | 1 | Response came from the cache |
| fetch_data | output | DW | Returned instruction word |
| mem_req | output | 1 | Memory read request, held until `mem_valid` |
| mem_addr | output | AW | Memory word address |
| mem_valid | input | 1 | Memory returns one word |
| mem_data | input | DW | Memory read data |

## Verification
A wrong valid bit or tag shows up at the very next fetch to that line. The response's hit flag flips, and the number of memory beats changes from 0 to 4, or from 4 to 0. A corrupt replacement order stays hidden until the next allocation, and then shows as a miss on a line that should have survived. The bench therefore runs an independent model through long orderings of hits and misses, and checks every response. A load abandoned too early or too late shows directly in the beat count taken during that load.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FILL   = 2'd1,
    ST_SINGLE = 2'd2
  } fill_state_e;

  localparam int STAT_EN_BIT  = 0;
  localparam int STAT_FRZ_BIT = 1;
  localparam int STAT_CLR_BIT = 2;
  localparam int STAT_W       = 3;
endpackage

// File: rtl/ifc_ctl_bits.sv
module ifc_ctl_bits
  import ifc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              wd_en,
  input  logic              wd_frz,
  input  logic              wd_clr,
  output logic              cfg_en,
  output logic              cfg_frz,
  output logic              clr_now,
  output logic [STAT_W-1:0] status
);
  logic en_q, frz_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      frz_q <= 1'b0;
    end else if (we) begin
      en_q  <= wd_en;
      frz_q <= wd_frz;
    end
  end

  // the clear bit is never stored: it acts in the cycle it is written
  assign clr_now = we && wd_clr;
  assign cfg_en  = en_q;
  assign cfg_frz = frz_q;

  always_comb begin
    status               = '0;
    status[STAT_EN_BIT]  = en_q;
    status[STAT_FRZ_BIT] = frz_q;
    status[STAT_CLR_BIT] = 1'b0;
  end

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cfg_en == $past(wd_en) && cfg_frz == $past(wd_frz)))
    else $error("control bits did not load"); // R10
endmodule

// File: rtl/ifc_lru.sv
module ifc_lru #(
  parameter int LINES = 4,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch,
  input  logic [IDXW-1:0]            touch_idx,
  output logic [IDXW-1:0]            victim,
  output logic [LINES-1:0][IDXW-1:0] stack_o
);
  typedef logic [LINES-1:0][IDXW-1:0] stack_t;

  stack_t stk_q;

  // move idx to slot 0 and shift the entries above its old slot down by one
  function automatic stack_t promote(stack_t s, logic [IDXW-1:0] idx);
    stack_t r;
    logic   seen;
    seen = 1'b0;
    r    = s;
    r[0] = idx;
    for (int k = 1; k < LINES; k++) begin
      if (s[k-1] == idx) seen = 1'b1;
      r[k] = seen ? s[k] : s[k-1];
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < LINES; k++) stk_q[k] <= IDXW'(k);
    end else if (touch) begin
      stk_q <= promote(stk_q, touch_idx);
    end
  end

  assign victim  = stk_q[LINES-1];
  assign stack_o = stk_q;

  AST_TOUCHED_NOT_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    touch |=> (victim != $past(touch_idx)))
    else $error("just-used line became the victim"); // R5
endmodule

// File: rtl/ifc_line_store.sv
module ifc_line_store #(
  parameter int LINES = 4,
  parameter int WPL   = 4,
  parameter int DW    = 32,
  parameter int TAGW  = 14,
  localparam int IDXW = $clog2(LINES),
  localparam int OFFW = $clog2(WPL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAGW-1:0]  look_tag,
  input  logic [OFFW-1:0]  look_off,
  output logic             hit_any,
  output logic [IDXW-1:0]  hit_idx,
  output logic [DW-1:0]    rd_word,
  input  logic             wr_en,
  input  logic [IDXW-1:0]  wr_idx,
  input  logic [OFFW-1:0]  wr_off,
  input  logic [DW-1:0]    wr_data,
  input  logic             drop_en,
  input  logic [IDXW-1:0]  drop_idx,
  input  logic             set_en,
  input  logic [IDXW-1:0]  set_idx,
  input  logic [TAGW-1:0]  set_tag,
  input  logic             clear_all,
  output logic [LINES-1:0] valid_o
);
  logic [LINES-1:0]           valid_q;
  logic [TAGW-1:0]            tag_q  [LINES];
  logic [WPL-1:0][DW-1:0]     data_q [LINES];
  logic [LINES-1:0]           hit_vec;

  for (genvar g = 0; g < LINES; g++) begin : g_cmp
    assign hit_vec[g] = valid_q[g] && (tag_q[g] == look_tag);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (hit_vec[i]) hit_idx = IDXW'(i);
    end
  end

  assign hit_any = |hit_vec;
  assign rd_word = data_q[hit_idx][look_off];
  assign valid_o = valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (clear_all) begin
      valid_q <= '0;
    end else begin
      if (drop_en) valid_q[drop_idx] <= 1'b0;
      if (set_en) begin
        valid_q[set_idx] <= 1'b1;
        tag_q[set_idx]   <= set_tag;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) data_q[wr_idx][wr_off] <= wr_data;
  end

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec))
    else $error("tag present in two lines"); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear_all |=> (valid_q == '0))
    else $error("clear left a valid line"); // R8
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import ifc_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LINES = 4,
  parameter int WPL   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic              ctl_en,
  input  logic              ctl_frz,
  input  logic              ctl_clr,
  output logic [STAT_W-1:0] ctl_status,
  input  logic              fetch_req,
  input  logic [AW-1:0]     fetch_addr,
  output logic              fetch_ready,
  output logic              fetch_valid,
  output logic              fetch_hit,
  output logic [DW-1:0]     fetch_data,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_valid,
  input  logic [DW-1:0]     mem_data
);
  localparam int OFFW = $clog2(WPL);
  localparam int IDXW = $clog2(LINES);
  localparam int TAGW = AW - OFFW;

  function automatic logic [TAGW-1:0] tag_of(logic [AW-1:0] a);
    return a[AW-1:OFFW];
  endfunction

  function automatic logic [OFFW-1:0] off_of(logic [AW-1:0] a);
    return a[OFFW-1:0];
  endfunction

  function automatic logic [AW-1:0] beat_addr(logic [TAGW-1:0] t, logic [OFFW-1:0] b);
    return {t, b};
  endfunction

  // control bits
  logic cfg_en, cfg_frz, clr_now;

  ifc_ctl_bits u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (ctl_we),
    .wd_en   (ctl_en),
    .wd_frz  (ctl_frz),
    .wd_clr  (ctl_clr),
    .cfg_en  (cfg_en),
    .cfg_frz (cfg_frz),
    .clr_now (clr_now),
    .status  (ctl_status)
  );

  // sequencer state
  fill_state_e     state_q;
  logic [AW-1:0]   req_addr_q;
  logic [IDXW-1:0] victim_q;
  logic [OFFW-1:0] beat_q;
  logic            killed_q;
  logic            delivered_q;
  logic            rsp_valid_q, rsp_hit_q;
  logic [DW-1:0]   rsp_data_q;

  // lookup and replacement
  logic                       hit_any;
  logic [IDXW-1:0]            hit_idx;
  logic [DW-1:0]              hit_word;
  logic [LINES-1:0]           line_valid;
  logic [LINES-1:0][IDXW-1:0] lru_stack;
  logic [IDXW-1:0]            lru_victim;

  // named internal events
  logic            accept, hit_now, fill_start, single_start;
  logic            fill_beat, word_match, beat_last, killed_next;
  logic            fill_done, commit, fill_wr, lru_touch;
  logic [IDXW-1:0] lru_idx;

  assign accept       = fetch_req && (state_q == ST_IDLE);
  assign hit_now      = accept && cfg_en && hit_any;
  assign fill_start   = accept && cfg_en && !cfg_frz && !hit_any;
  assign single_start = accept && !hit_now && !fill_start;

  assign fill_beat   = (state_q == ST_FILL) && mem_valid;
  assign word_match  = (beat_q == off_of(req_addr_q));
  assign beat_last   = (beat_q == OFFW'(WPL - 1));
  assign killed_next = killed_q || clr_now;
  assign fill_done   = fill_beat && (beat_last || (killed_next && (delivered_q || word_match)));
  assign commit      = fill_beat && beat_last && !killed_next && cfg_en && !cfg_frz;
  assign fill_wr     = fill_beat && !killed_next;
  assign lru_touch   = (hit_now && !cfg_frz) || commit;
  assign lru_idx     = hit_now ? hit_idx : victim_q;

  ifc_line_store #(
    .LINES (LINES),
    .WPL   (WPL),
    .DW    (DW),
    .TAGW  (TAGW)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .look_tag  (tag_of(fetch_addr)),
    .look_off  (off_of(fetch_addr)),
    .hit_any   (hit_any),
    .hit_idx   (hit_idx),
    .rd_word   (hit_word),
    .wr_en     (fill_wr),
    .wr_idx    (victim_q),
    .wr_off    (beat_q),
    .wr_data   (mem_data),
    .drop_en   (fill_start),
    .drop_idx  (lru_victim),
    .set_en    (commit),
    .set_idx   (victim_q),
    .set_tag   (tag_of(req_addr_q)),
    .clear_all (clr_now),
    .valid_o   (line_valid)
  );

  ifc_lru #(
    .LINES (LINES)
  ) u_lru (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch     (lru_touch),
    .touch_idx (lru_idx),
    .victim    (lru_victim),
    .stack_o   (lru_stack)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      req_addr_q  <= '0;
      victim_q    <= '0;
      beat_q      <= '0;
      killed_q    <= 1'b0;
      delivered_q <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      rsp_hit_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (fill_start) begin
            state_q     <= ST_FILL;
            req_addr_q  <= fetch_addr;
            victim_q    <= lru_victim;
            beat_q      <= '0;
            killed_q    <= clr_now;
            delivered_q <= 1'b0;
          end else if (single_start) begin
            state_q    <= ST_SINGLE;
            req_addr_q <= fetch_addr;
          end else if (hit_now) begin
            rsp_valid_q <= 1'b1;
            rsp_hit_q   <= 1'b1;
            rsp_data_q  <= hit_word;
          end
        end
        ST_FILL: begin
          if (clr_now) killed_q <= 1'b1;
          if (fill_beat) begin
            beat_q <= beat_q + OFFW'(1);
            if (word_match) begin
              rsp_valid_q <= 1'b1;
              rsp_data_q  <= mem_data;
              delivered_q <= 1'b1;
            end
            if (fill_done) state_q <= ST_IDLE;
          end
        end
        ST_SINGLE: begin
          if (mem_valid) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= mem_data;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_ready = (state_q == ST_IDLE);
  assign fetch_valid = rsp_valid_q;
  assign fetch_hit   = rsp_hit_q;
  assign fetch_data  = rsp_data_q;
  assign mem_req     = (state_q != ST_IDLE);
  assign mem_addr    = (state_q == ST_FILL) ? beat_addr(tag_of(req_addr_q), beat_q) : req_addr_q;

  AST_DISABLED_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cfg_en) |=> (state_q == ST_SINGLE && !fetch_hit))
    else $error("disabled cache did not bypass"); // R2

  AST_FILL_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_beat && !fill_done) |=> (mem_addr == $past(mem_addr) + AW'(1)))
    else $error("fill beats out of order"); // R3

  AST_HIT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    hit_now |=> (fetch_valid && fetch_hit))
    else $error("hit not answered next cycle"); // R4

  AST_FROZEN_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_frz && !clr_now) |=> $stable(line_valid))
    else $error("frozen cache changed its valid bits"); // R6

  AST_FROZEN_KEEPS_LRU: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_frz |=> $stable(lru_stack))
    else $error("frozen cache reordered LRU"); // R7

  AST_KILLED_FILL_NO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL && killed_q) |=> (line_valid == '0))
    else $error("aborted fill validated a line"); // R9
endmodule

// File: tb/ifetch_cache_tb_top.sv
`timescale 1ns/1ps
module ifetch_cache_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0, ctl_en = 1'b0, ctl_frz = 1'b0, ctl_clr = 1'b0;
  logic [2:0]  ctl_status;
  logic        fetch_req = 1'b0;
  logic [15:0] fetch_addr = '0;
  logic        fetch_ready, fetch_valid, fetch_hit;
  logic [31:0] fetch_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_valid = 1'b0;
  logic [31:0] mem_data = '0;

  always #4 clk = ~clk;

  ifetch_cache dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(ctl_we), .ctl_en(ctl_en), .ctl_frz(ctl_frz), .ctl_clr(ctl_clr),
    .ctl_status(ctl_status),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ready(fetch_ready),
    .fetch_valid(fetch_valid), .fetch_hit(fetch_hit), .fetch_data(fetch_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_data(mem_data)
  );

  int total = 0;
  int bad   = 0;

  function automatic logic [31:0] pattern(logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // external memory: two-cycle wait per word
  int          beats = 0;
  int          wcnt  = 0;
  logic [15:0] alog[$];
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_valid = 1'b0;
      wcnt = 0;
    end else if (mem_valid) begin
      mem_valid = 1'b0;
    end else if (mem_req) begin
      wcnt++;
      if (wcnt >= 2) begin
        mem_valid = 1'b1;
        mem_data  = pattern(mem_addr);
        wcnt = 0;
        beats++;
        alog.push_back(mem_addr);
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] d;
    logic        h;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && fetch_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R3", "unexpected response", fetch_data, 32'h0);
      end else begin
        e = sbq.pop_front();
        chk(fetch_data == e.d, e.tag, "data", fetch_data, e.d);
        chk(fetch_hit == e.h, e.tag, "hit flag", 32'(fetch_hit), 32'(e.h));
      end
    end
  end

  // reference model: front of m_lru is most recent
  bit          m_en = 0, m_frz = 0;
  bit          m_vld[4];
  logic [13:0] m_tag[4];
  int          m_lru[$];

  task automatic m_touch(int li);
    foreach (m_lru[k]) if (m_lru[k] == li) begin m_lru.delete(k); break; end
    m_lru.push_front(li);
  endtask

  task automatic drive_req(logic [15:0] a);
    while (!fetch_ready) @(negedge clk);
    fetch_req  = 1'b1;
    fetch_addr = a;
    @(negedge clk);
    fetch_req = 1'b0;
  endtask

  task automatic do_fetch(logic [15:0] a, string tag);
    exp_t e;
    int   li;
    bit   eh;
    eh = 0;
    li = -1;
    if (m_en) for (int i = 0; i < 4; i++) if (m_vld[i] && m_tag[i] == a[15:2]) begin eh = 1; li = i; end
    e.d = pattern(a); e.h = eh; e.tag = tag;
    sbq.push_back(e);
    if (eh && !m_frz) m_touch(li);
    else if (!eh && m_en && !m_frz) begin
      li = m_lru[$];
      m_vld[li] = 1;
      m_tag[li] = a[15:2];
      m_touch(li);
    end
    @(negedge clk);
    drive_req(a);
    if (eh) chk(fetch_valid && fetch_hit, "R4", "hit response next cycle", 32'({fetch_valid, fetch_hit}), 32'h3);
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(bit en, bit frz, bit clr);
    @(negedge clk);
    ctl_we = 1'b1; ctl_en = en; ctl_frz = frz; ctl_clr = clr;
    @(negedge clk);
    ctl_we = 1'b0; ctl_clr = 1'b0;
    m_en = en; m_frz = frz;
    if (clr) foreach (m_vld[i]) m_vld[i] = 0;
    chk(ctl_status == {1'b0, frz, en}, "R10", "status readback", 32'(ctl_status), 32'({1'b0, frz, en}));
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int b0;
    m_lru = '{0, 1, 2, 3};
    foreach (m_vld[i]) m_vld[i] = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctl_status == 3'b000, "R1", "status after reset", 32'(ctl_status), 32'h0);
    chk(!fetch_valid && !mem_req && fetch_ready, "R1", "idle outputs",
        32'({fetch_valid, mem_req, fetch_ready}), 32'h1);

    // R2 disabled: single word bypass, no allocation
    b0 = beats;
    do_fetch(16'h0010, "R2");
    chk(beats - b0 == 1, "R2", "beats while disabled", 32'(beats - b0), 32'd1);
    do_fetch(16'h0010, "R2");

    // R3 enable and fill
    wr_ctl(1, 0, 0);
    alog.delete();
    b0 = beats;
    do_fetch(16'h0012, "R2");
    chk(beats - b0 == 4, "R3", "beats per fill", 32'(beats - b0), 32'd4);
    for (int k = 0; k < 4; k++)
      chk(alog[k] == 16'h0010 + 16'(k), "R3", "fill order", 32'(alog[k]), 32'(16'h0010 + 16'(k)));
    b0 = beats;
    do_fetch(16'h0010, "R3");
    do_fetch(16'h0013, "R3");
    do_fetch(16'h0011, "R4");
    chk(beats == b0, "R3", "hits use no memory", 32'(beats - b0), 32'd0);

    // R5 replacement order
    wr_ctl(1, 0, 1);
    do_fetch(16'h0100, "R5");
    do_fetch(16'h0201, "R5");
    do_fetch(16'h0302, "R5");
    do_fetch(16'h0403, "R5");
    do_fetch(16'h0101, "R5");
    do_fetch(16'h0500, "R5");
    do_fetch(16'h0102, "R5");
    do_fetch(16'h0300, "R5");
    do_fetch(16'h0401, "R5");
    do_fetch(16'h0203, "R5");
    do_fetch(16'h0501, "R5");

    // R6 / R7 frozen
    wr_ctl(1, 1, 0);
    do_fetch(16'h0301, "R6");
    b0 = beats;
    do_fetch(16'h0600, "R6");
    chk(beats - b0 == 1, "R6", "frozen miss beats", 32'(beats - b0), 32'd1);
    do_fetch(16'h0600, "R6");
    wr_ctl(1, 0, 0);
    do_fetch(16'h0700, "R7");
    do_fetch(16'h0302, "R7");
    do_fetch(16'h0201, "R7");

    // R8 clear while frozen
    wr_ctl(1, 1, 1);
    do_fetch(16'h0700, "R8");
    wr_ctl(1, 0, 0);
    do_fetch(16'h0302, "R8");

    // R9 clear during a fill
    begin
      exp_t e;
      e.d = pattern(16'h0801); e.h = 1'b0; e.tag = "R9";
      sbq.push_back(e);
      b0 = beats;
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      fetch_req = 1'b1; fetch_addr = 16'h0801;
      @(negedge clk);
      fetch_req = 1'b0;
      ctl_we = 1'b1; ctl_en = 1'b1; ctl_frz = 1'b0; ctl_clr = 1'b1;
      @(negedge clk);
      ctl_we = 1'b0; ctl_clr = 1'b0;
      foreach (m_vld[i]) m_vld[i] = 0;
      while (!fetch_ready) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(beats - b0 == 2, "R9", "beats of aborted fill", 32'(beats - b0), 32'd2);
    end
    do_fetch(16'h0801, "R9");
    do_fetch(16'h0302, "R9");

    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R3", "responses outstanding", 32'(sbq.size()), 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule